// File: doc/BRIEF.md
# Transmit Descriptor Ring Sequencer

This block owns a small local memory of transmit descriptors that are arranged as a ring. Each descriptor has three fields: a 16-bit status word, a 16-bit frame length and a 32-bit buffer pointer. The host fills a descriptor and sets its ready bit to hand it to the engine. The engine then issues a frame request to an external transmitter and holds it until the transmitter answers with done. After done, the engine writes the status back with the ready bit cleared, so the host owns the descriptor again. It then moves on to the next descriptor, or returns to the ring base after a descriptor that carries the wrap flag.

When the engine reaches a descriptor that is not ready, it halts. It stays halted until the host issues a clear-halt pulse. A graceful stop request lets any frame already in flight complete, then parks the engine and raises a stop event. Two events, frame-complete and stop-complete, are ANDed with a mask to drive a single interrupt line. The host clears each event by writing 1 to it. The frame payload, the serialiser and bus mastering all belong to neighbouring blocks.

Top module: `txr_engine`

## Requirements
- R1: After reset the engine is halted, no request is asserted, the current index is 0, and both events and the interrupt are low.
- R2: When the engine is not halted or stopping and the descriptor at the current index has ready (status bit 15) set, it asserts req_valid_o with that descriptor's pointer and length. req_crc_o equals status bit 10. All of these hold steady until done_i.
- R3: On done_i the status word of that descriptor is written back with bit 15 cleared, its low ERR_W bits replaced by err_i, and every other bit kept.
- R4: After a completion the current index becomes ring_base_i if the descriptor had wrap (status bit 13) set. Otherwise it advances by one, rolling from DEPTH-1 to 0.
- R5: A descriptor found with bit 15 clear sets halted_o. No request is issued while the engine is halted.
- R6: A clear_halt_i pulse clears halted_o, and fetching resumes at the current index.
- R7: While gts_req_i is high, a frame in flight still completes. Afterwards stopped_o and event bit 1 go high, and no new request is issued until gts_req_i falls.
- R8: A completed descriptor with the interrupt bit (status bit 12) set raises event bit 0. One without it leaves bit 0 unchanged. Writing 1 in ev_clr_i clears the matching event, and a same-cycle set wins.
- R9: irq_o is high exactly when some bit of events_o & irq_mask_i is set.
- R10: An idx_rst_i pulse loads the current index from ring_base_i. The pulse is ignored while a request is outstanding.
- R11: The host port addresses a descriptor by host_idx_i. Word 0 is {status, length} and word 1 is the pointer. Writes take effect at the next edge, and reads return the stored word combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_we_i | input | 1 | Host write strobe |
| host_idx_i | input | IDX_W | Host descriptor index |
| host_word_i | input | 1 | 0: {status,length}, 1: pointer |
| host_wdata_i | input | 32 | Host write data |
| host_rdata_o | output | 32 | Host read data |
| ring_base_i | input | IDX_W | Ring base index |
| idx_rst_i | input | 1 | Load current index from ring base |
| clear_halt_i | input | 1 | Clear the halt flag |
| gts_req_i | input | 1 | Graceful stop request (level) |
| ev_clr_i | input | 2 | Write-1-to-clear for the events |
| irq_mask_i | input | 2 | Interrupt mask |
| req_valid_o | output | 1 | Frame request pending |
| req_ptr_o | output | 32 | Frame buffer pointer |
| req_len_o | output | 16 | Frame length |
| req_crc_o | output | 1 | Append-CRC flag |
| done_i | input | 1 | Transmitter completion |
| err_i | input | ERR_W | Transmitter error flags |
| halted_o | output | 1 | Halt flag |
| stopped_o | output | 1 | Parked by graceful stop |
| cur_idx_o | output | IDX_W | Current descriptor index |
| events_o | output | 2 | bit0 frame done, bit1 stop done |
| irq_o | output | 1 | Interrupt |

## Verification
The bench builds the engine with DEPTH=4 and ERR_W=4. A four-entry ring is small enough that one run can cover three index changes: a wrap-flag return to base, a return to a non-zero base, and a halt on a descriptor the host still owns. Four error bits let a non-trivial pattern (0x5) be traced through write-back alongside bits that must survive. A graceful stop is raised mid-frame while a later descriptor is already ready, so the bench can observe both that the frame finishes and that nothing new is issued while the engine is parked.

// File: rtl/txr_pkg.sv
package txr_pkg;
  localparam int ST_READY = 15;
  localparam int ST_WRAP  = 13;
  localparam int ST_INTR  = 12;
  localparam int ST_LAST  = 11;
  localparam int ST_CRC   = 10;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_BUSY = 2'd1,
    S_STOP = 2'd2
  } seq_state_e;
endpackage

// File: rtl/txr_desc_mem.sv
module txr_desc_mem #(
  parameter int DEPTH = 16,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             host_we_i,
  input  logic [IDX_W-1:0] host_idx_i,
  input  logic             host_word_i,
  input  logic [31:0]      host_wdata_i,
  output logic [31:0]      host_rdata_o,
  input  logic [IDX_W-1:0] eng_idx_i,
  output logic [15:0]      eng_status_o,
  output logic [15:0]      eng_len_o,
  output logic [31:0]      eng_ptr_o,
  input  logic             wb_en_i,
  input  logic [IDX_W-1:0] wb_idx_i,
  input  logic [15:0]      wb_status_i
);
  logic [15:0] status_q [DEPTH];
  logic [15:0] len_q    [DEPTH];
  logic [31:0] ptr_q    [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    logic host_hit, wb_hit;
    assign host_hit = host_we_i && (int'(host_idx_i) == g);
    assign wb_hit   = wb_en_i && (int'(wb_idx_i) == g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        status_q[g] <= '0;
        len_q[g]    <= '0;
        ptr_q[g]    <= '0;
      end else begin
        // engine write-back owns the status half on a collision
        if (wb_hit)
          status_q[g] <= wb_status_i;
        else if (host_hit && !host_word_i)
          status_q[g] <= host_wdata_i[31:16];
        if (host_hit && !host_word_i) len_q[g] <= host_wdata_i[15:0];
        if (host_hit && host_word_i)  ptr_q[g] <= host_wdata_i;
      end
    end
  end

  assign host_rdata_o = host_word_i ? ptr_q[host_idx_i]
                                    : {status_q[host_idx_i], len_q[host_idx_i]};
  assign eng_status_o = status_q[eng_idx_i];
  assign eng_len_o    = len_q[eng_idx_i];
  assign eng_ptr_o    = ptr_q[eng_idx_i];

  a_r3_ready_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_i |=> !status_q[$past(wb_idx_i)][txr_pkg::ST_READY]);
endmodule

// File: rtl/txr_seq.sv
module txr_seq
  import txr_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int ERR_W = 4,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [15:0]      d_status_i,
  input  logic [15:0]      d_len_i,
  input  logic [31:0]      d_ptr_i,
  output logic [IDX_W-1:0] cur_idx_o,
  input  logic [IDX_W-1:0] ring_base_i,
  input  logic             idx_rst_i,
  input  logic             clear_halt_i,
  input  logic             gts_req_i,
  output logic             req_valid_o,
  output logic [31:0]      req_ptr_o,
  output logic [15:0]      req_len_o,
  output logic             req_crc_o,
  input  logic             done_i,
  input  logic [ERR_W-1:0] err_i,
  output logic             wb_en_o,
  output logic [15:0]      wb_status_o,
  output logic             frame_set_o,
  output logic             stop_set_o,
  output logic             halted_o,
  output logic             stopped_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  seq_state_e  state_q, state_d;
  logic        halted_q;
  logic [IDX_W-1:0] cur_q;
  logic [15:0] st_q;
  logic [15:0] len_q;
  logic [31:0] ptr_q;
  logic        fetch_ok, finish;
  logic [IDX_W-1:0] next_idx;

  assign finish   = (state_q == S_BUSY) && done_i;
  assign fetch_ok = (state_q == S_IDLE) && !gts_req_i && !halted_q &&
                    d_status_i[ST_READY];

  always_comb begin
    if (st_q[ST_WRAP])         next_idx = ring_base_i;
    else if (cur_q == LAST_IDX) next_idx = '0;
    else                       next_idx = cur_q + 1'b1;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: if (gts_req_i) state_d = S_STOP;
              else if (fetch_ok) state_d = S_BUSY;
      S_BUSY: if (done_i) state_d = S_IDLE;
      S_STOP: if (!gts_req_i) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      halted_q <= 1'b1;
      cur_q    <= '0;
      st_q     <= '0;
      len_q    <= '0;
      ptr_q    <= '0;
    end else begin
      state_q <= state_d;
      if (clear_halt_i)
        halted_q <= 1'b0;
      else if (state_q == S_IDLE && !gts_req_i && !halted_q && !d_status_i[ST_READY])
        halted_q <= 1'b1;
      if (fetch_ok) begin
        st_q  <= d_status_i;
        len_q <= d_len_i;
        ptr_q <= d_ptr_i;
      end
      if (finish)
        cur_q <= next_idx;
      else if (idx_rst_i && state_q != S_BUSY)
        cur_q <= ring_base_i;
    end
  end

  assign cur_idx_o   = cur_q;
  assign req_valid_o = (state_q == S_BUSY);
  assign req_ptr_o   = ptr_q;
  assign req_len_o   = len_q;
  assign req_crc_o   = st_q[ST_CRC];
  assign wb_en_o     = finish;
  assign wb_status_o = {1'b0, st_q[14:ERR_W], err_i};
  assign frame_set_o = finish && st_q[ST_INTR];
  assign stop_set_o  = (state_q == S_IDLE) && gts_req_i;
  assign halted_o    = halted_q;
  assign stopped_o   = (state_q == S_STOP);

  a_r2_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !done_i) |=> (req_valid_o && $stable(req_ptr_o) && $stable(req_len_o)));
  a_r4_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (finish && !st_q[ST_WRAP] && cur_q != LAST_IDX) |=> (cur_q == $past(cur_q) + 1'b1));
  a_r5_halt_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halted_o && !clear_halt_i && !req_valid_o) |=> !req_valid_o);
  a_r7_stop_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stopped_o && gts_req_i) |=> (stopped_o && !req_valid_o));
endmodule

// File: rtl/txr_events.sv
module txr_events #(
  parameter int NEV = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NEV-1:0] set_i,
  input  logic [NEV-1:0] clr_i,
  input  logic [NEV-1:0] mask_i,
  output logic [NEV-1:0] ev_o,
  output logic           irq_o
);
  logic [NEV-1:0] ev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ev_q <= '0;
    else         ev_q <= set_i | (ev_q & ~clr_i);
  end

  assign ev_o  = ev_q;
  assign irq_o = |(ev_q & mask_i);

  a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((ev_o & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/txr_engine.sv
module txr_engine #(
  parameter int DEPTH = 16,
  parameter int ERR_W = 4,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             host_we_i,
  input  logic [IDX_W-1:0] host_idx_i,
  input  logic             host_word_i,
  input  logic [31:0]      host_wdata_i,
  output logic [31:0]      host_rdata_o,
  input  logic [IDX_W-1:0] ring_base_i,
  input  logic             idx_rst_i,
  input  logic             clear_halt_i,
  input  logic             gts_req_i,
  input  logic [1:0]       ev_clr_i,
  input  logic [1:0]       irq_mask_i,
  output logic             req_valid_o,
  output logic [31:0]      req_ptr_o,
  output logic [15:0]      req_len_o,
  output logic             req_crc_o,
  input  logic             done_i,
  input  logic [ERR_W-1:0] err_i,
  output logic             halted_o,
  output logic             stopped_o,
  output logic [IDX_W-1:0] cur_idx_o,
  output logic [1:0]       events_o,
  output logic             irq_o
);
  logic [15:0] d_status, d_len, wb_status;
  logic [31:0] d_ptr;
  logic        wb_en, frame_set, stop_set;
  logic [IDX_W-1:0] cur_idx;

  txr_desc_mem #(.DEPTH(DEPTH)) u_mem (
    .clk_i, .rst_ni,
    .host_we_i, .host_idx_i, .host_word_i, .host_wdata_i, .host_rdata_o,
    .eng_idx_i(cur_idx), .eng_status_o(d_status), .eng_len_o(d_len), .eng_ptr_o(d_ptr),
    .wb_en_i(wb_en), .wb_idx_i(cur_idx), .wb_status_i(wb_status)
  );

  txr_seq #(.DEPTH(DEPTH), .ERR_W(ERR_W)) u_seq (
    .clk_i, .rst_ni,
    .d_status_i(d_status), .d_len_i(d_len), .d_ptr_i(d_ptr),
    .cur_idx_o(cur_idx), .ring_base_i, .idx_rst_i, .clear_halt_i, .gts_req_i,
    .req_valid_o, .req_ptr_o, .req_len_o, .req_crc_o, .done_i, .err_i,
    .wb_en_o(wb_en), .wb_status_o(wb_status),
    .frame_set_o(frame_set), .stop_set_o(stop_set),
    .halted_o, .stopped_o
  );

  txr_events #(.NEV(2)) u_ev (
    .clk_i, .rst_ni,
    .set_i({stop_set, frame_set}), .clr_i(ev_clr_i), .mask_i(irq_mask_i),
    .ev_o(events_o), .irq_o
  );

  assign cur_idx_o = cur_idx;

  a_r9_irq_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o == |(events_o & irq_mask_i)));
  a_r7_stop_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stopped_o) |-> events_o[1]);
endmodule

// File: tb/sim_txr_engine.sv
module sim_txr_engine;
  localparam int DEPTH = 4;
  localparam int ERR_W = 4;
  localparam int IDX_W = 2;

  logic clk = 0, rst_n = 0;
  logic host_we = 0, host_word = 0;
  logic [IDX_W-1:0] host_idx = '0, ring_base = '0;
  logic [31:0] host_wdata = '0, host_rdata;
  logic idx_rst = 0, clear_halt = 0, gts = 0, done = 0;
  logic [1:0] ev_clr = '0, irq_mask = '0, events;
  logic [ERR_W-1:0] err = '0;
  logic req_valid, req_crc, halted, stopped, irq;
  logic [31:0] req_ptr;
  logic [15:0] req_len;
  logic [IDX_W-1:0] cur_idx;
  int n_chk = 0, n_bad = 0, cyc = 0;

  always #10 clk = ~clk;

  txr_engine #(.DEPTH(DEPTH), .ERR_W(ERR_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .host_we_i(host_we), .host_idx_i(host_idx), .host_word_i(host_word),
    .host_wdata_i(host_wdata), .host_rdata_o(host_rdata),
    .ring_base_i(ring_base), .idx_rst_i(idx_rst), .clear_halt_i(clear_halt),
    .gts_req_i(gts), .ev_clr_i(ev_clr), .irq_mask_i(irq_mask),
    .req_valid_o(req_valid), .req_ptr_o(req_ptr), .req_len_o(req_len), .req_crc_o(req_crc),
    .done_i(done), .err_i(err), .halted_o(halted), .stopped_o(stopped),
    .cur_idx_o(cur_idx), .events_o(events), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected <20000 cycles", cyc);
      finish_run();
    end
  end

  task automatic wr(input int idx, input logic word, input logic [31:0] d);
    @(negedge clk);
    host_we = 1; host_idx = IDX_W'(idx); host_word = word; host_wdata = d;
    @(negedge clk);
    host_we = 0;
  endtask

  task automatic rd(input int idx, input logic word, output logic [31:0] d);
    host_idx = IDX_W'(idx); host_word = word;
    #1 d = host_rdata;
  endtask

  task automatic pulse_clr_halt();
    @(negedge clk); clear_halt = 1;
    @(negedge clk); clear_halt = 0;
  endtask

  task automatic wait_req(input string req);
    int k = 0;
    while (!req_valid && k < 20) begin @(negedge clk); k++; end
    chk(req, {31'd0, req_valid}, 32'd1);
  endtask

  task automatic complete(input logic [ERR_W-1:0] e);
    done = 1; err = e;
    @(negedge clk);
    done = 0; err = '0;
  endtask

  task automatic t_reset();
    chk("R1 halted", {31'd0, halted}, 32'd1);
    chk("R1 no req", {31'd0, req_valid}, 32'd0);
    chk("R1 idx", {30'd0, cur_idx}, 32'd0);
    chk("R1 events", {29'd0, irq, events}, 32'd0);
  endtask

  task automatic t_basic();
    logic [31:0] d;
    wr(0, 0, {16'h9C00, 16'd64});  wr(0, 1, 32'h1000_0000);
    wr(1, 0, {16'h8400, 16'd100}); wr(1, 1, 32'h2000_0040);
    rd(1, 1, d);
    chk("R11 ptr readback", d, 32'h2000_0040);
    repeat (3) @(negedge clk);
    chk("R5 no req while halted", {31'd0, req_valid}, 32'd0);
    pulse_clr_halt();
    chk("R6 halt cleared", {31'd0, halted}, 32'd0);
    wait_req("R6 resume");
    chk("R2 ptr", req_ptr, 32'h1000_0000);
    chk("R2 len", {16'd0, req_len}, 32'd64);
    chk("R2 crc", {31'd0, req_crc}, 32'd1);
    repeat (3) @(negedge clk);
    chk("R2 hold", req_ptr, 32'h1000_0000);
    irq_mask = 2'b01;
    complete(4'h5);
    rd(0, 0, d);
    chk("R3 writeback", d, {16'h1C05, 16'd64});
    chk("R4 advance", {30'd0, cur_idx}, 32'd1);
    chk("R8 frame event", {30'd0, events}, 32'd1);
    chk("R9 irq", {31'd0, irq}, 32'd1);
    @(negedge clk); ev_clr = 2'b01; @(negedge clk); ev_clr = 2'b00;
    chk("R8 w1c", {30'd0, events}, 32'd0);
    wait_req("R2 second");
    chk("R2 len2", {16'd0, req_len}, 32'd100);
    complete(4'h0);
    chk("R8 no intr no event", {30'd0, events}, 32'd0);
    repeat (3) @(negedge clk);
    chk("R5 halted on empty", {31'd0, halted}, 32'd1);
    chk("R5 idx kept", {30'd0, cur_idx}, 32'd2);
  endtask

  task automatic t_wrap();
    logic [31:0] d;
    wr(2, 0, {16'hA000, 16'd33}); wr(2, 1, 32'h3000_0000);
    pulse_clr_halt();
    wait_req("R2 third");
    chk("R2 crc off", {31'd0, req_crc}, 32'd0);
    complete(4'hF);
    chk("R4 wrap to base", {30'd0, cur_idx}, 32'd0);
    rd(2, 0, d);
    chk("R3 wrap kept", d, {16'h200F, 16'd33});
    repeat (3) @(negedge clk);
    chk("R5 halted at owned", {31'd0, halted}, 32'd1);
    irq_mask = 2'b00;
    @(negedge clk); ring_base = 2'd1; idx_rst = 1; @(negedge clk); idx_rst = 0;
    chk("R10 index reset", {30'd0, cur_idx}, 32'd1);
  endtask

  task automatic t_stop();
    wr(1, 0, {16'h9000, 16'd7});  wr(1, 1, 32'h4000_0000);
    wr(2, 0, {16'hA000, 16'd9});  wr(2, 1, 32'h5000_0000);
    pulse_clr_halt();
    wait_req("R7 frame before stop");
    chk("R2 ptr4", req_ptr, 32'h4000_0000);
    gts = 1;
    @(negedge clk); idx_rst = 1; @(negedge clk); idx_rst = 0;
    @(negedge clk);
    chk("R10 ignored in flight", {30'd0, cur_idx}, 32'd1);
    chk("R7 frame continues", {31'd0, req_valid}, 32'd1);
    chk("R7 no early stop", {31'd0, events[1]}, 32'd0);
    complete(4'h0);
    @(negedge clk);
    chk("R7 stopped", {31'd0, stopped}, 32'd1);
    chk("R7 stop event", {30'd0, events}, 32'd3);
    chk("R9 masked", {31'd0, irq}, 32'd0);
    irq_mask = 2'b10;
    #1 chk("R9 stop irq", {31'd0, irq}, 32'd1);
    repeat (5) @(negedge clk);
    chk("R7 no req when stopped", {31'd0, req_valid}, 32'd0);
    gts = 0;
    wait_req("R7 resume");
    chk("R2 ptr5", req_ptr, 32'h5000_0000);
    complete(4'h0);
    chk("R4 wrap to base 1", {30'd0, cur_idx}, 32'd1);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_basic();
    t_wrap();
    t_stop();
    finish_run();
  end
endmodule